// File: doc/BRIEF.md
# Multiplexed Bus Address Decoder and Strobe Glue

This block connects a small microcontroller's multiplexed external bus to the parts hung off it. The low address byte and the data byte share one port. The block captures the low byte while the address strobe is high and joins it with the high address byte into a full 16-bit address. It then decodes that address into active-low chip enables for four targets:

- an 8K code EEPROM in the lower half of the map;
- a 32K SRAM in the upper half, used for both code and data;
- a one-byte LED output register that the block holds itself;
- a four-register I/O expander window, which also receives two register-select bits.

The processor's program-fetch, read and write strobes are combined into output and write enables for the two memories. Either fetch or read opens the SRAM outputs. Only fetch opens the EEPROM outputs. For data accesses the two peripheral windows, which lie inside the SRAM half, take priority over the SRAM. A static mode input picks between two decoding styles. Complete decoding compares every address bit above a window's size. Partial decoding compares only the top nibble, so each peripheral then answers across a whole 4K block.

Top module: `bus_glue`

## Requirements
- R1: While `ale_i` is high, `mem_addr_o[7:0]` takes the value of `ad_i` at each rising clock edge. While `ale_i` is low it holds, and `mem_addr_o[15:8]` always equals `addr_hi_i`.
- R2: `eeprom_ce_no` is 0 exactly when address bit 15 is 0, in both decoding modes and for every strobe state.
- R3: `sram_ce_no` is 0 when address bit 15 is 1. The one exception is a data access (`rd_ni` or `wr_ni` low with `psen_ni` high) that falls inside the LED or I/O expander window.
- R4: `sram_oe_no` is 0 exactly when `psen_ni` or `rd_ni` is 0, and `sram_we_no` equals `wr_ni`.
- R5: `eeprom_oe_no` equals `psen_ni` and does not depend on `rd_ni` or `wr_ni`.
- R6: With `partial_i`=0, the LED window is the single address 0xF000. The I/O expander window is 0xD000 to 0xD003. `iox_ce_no` is 0 only for a data access inside that window. `iox_sel_o` equals address bits 1:0.
- R7: With `partial_i`=1, the LED window is 0xF000 to 0xFFFF and the I/O expander window is 0xD000 to 0xDFFF. Otherwise the rules of R6 and R3 apply unchanged.
- R8: A rising clock edge with `wr_ni`=0, `psen_ni`=1 and the address in the LED window loads `ad_i` into `led_o`. A read of that window leaves `led_o` unchanged and asserts no chip enable.
- R9: `led_o` is 0x00 while `rst_ni` is 0 and after reset is released.
- R10: At most one of `eeprom_ce_no`, `sram_ce_no` and `iox_ce_no` is 0 at any time.
- R11: A program fetch (`psen_ni`=0) with address bit 15 set always asserts `sram_ce_no`, even inside a peripheral window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| partial_i | input | 1 | 1 selects partial decoding of the peripheral windows |
| ale_i | input | 1 | Address strobe; low byte is captured while high |
| ad_i | input | 8 | Shared low-address / data port |
| addr_hi_i | input | 8 | High address byte |
| psen_ni | input | 1 | Program fetch strobe, active low |
| rd_ni | input | 1 | Data read strobe, active low |
| wr_ni | input | 1 | Data write strobe, active low |
| mem_addr_o | output | 16 | Demultiplexed address |
| eeprom_ce_no | output | 1 | Code EEPROM chip enable |
| eeprom_oe_no | output | 1 | Code EEPROM output enable |
| sram_ce_no | output | 1 | SRAM chip enable |
| sram_oe_no | output | 1 | SRAM output enable |
| sram_we_no | output | 1 | SRAM write enable |
| iox_ce_no | output | 1 | I/O expander chip enable |
| iox_sel_o | output | 2 | I/O expander register select |
| led_o | output | 8 | LED register contents |

## Verification
The bench builds the block with its default parameters: a 16-bit address, the 0xF000 and 0xD000 peripheral bases, and a 4K partial-decoding granule. At this size the whole 64K map is small enough to sweep. In complete mode every address is visited under idle, fetch, read and write strobes, so every window edge, the single-byte LED hole and the mutual exclusion of the enables are all covered. Partial mode is swept over a quarter of the low-byte values, which still reaches every alias inside the two 4K peripheral blocks. Directed bus cycles cover loading and holding the LED register, including a write at an alias address and a read that must not disturb it.

// File: rtl/bus_glue_pkg.sv
`timescale 1ns/1ps
package bus_glue_pkg;

  localparam int unsigned NUM_WIN = 4;

  typedef enum logic [1:0] {
    WIN_ROM = 2'd0,
    WIN_RAM = 2'd1,
    WIN_LED = 2'd2,
    WIN_IOX = 2'd3
  } win_e;

  typedef struct packed {
    logic iox;
    logic led;
    logic ram;
    logic rom;
  } win_hit_t;

  typedef struct packed {
    logic fetch;
    logic data_rd;
    logic data_wr;
  } acc_t;

endpackage

// File: rtl/bus_addr_latch.sv
`timescale 1ns/1ps
module bus_addr_latch #(
  parameter int unsigned LO_W = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            ale_i,
  input  logic [LO_W-1:0] ad_i,
  output logic [LO_W-1:0] lo_o
);

  logic [LO_W-1:0] lo_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    lo_q <= '0;
    else if (ale_i) lo_q <= ad_i;
  end

  assign lo_o = lo_q;

endmodule

// File: rtl/bus_win_decode.sv
`timescale 1ns/1ps
module bus_win_decode #(
  parameter int unsigned    ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] BASE  = '0,
  parameter int unsigned    FULL_LSB = 0,
  parameter int unsigned    PART_LSB = 0
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              partial_i,
  output logic              hit_o
);

  localparam int unsigned EFF_PART = (PART_LSB > FULL_LSB) ? PART_LSB : FULL_LSB;
  localparam logic [ADDR_W-1:0] ONES      = {ADDR_W{1'b1}};
  localparam logic [ADDR_W-1:0] FULL_MASK = ONES << FULL_LSB;
  localparam logic [ADDR_W-1:0] PART_MASK = ONES << EFF_PART;

  logic [ADDR_W-1:0] diff;
  logic              full_hit, part_hit;

  assign diff     = addr_i ^ BASE;
  assign full_hit = ~|(diff & FULL_MASK);
  assign part_hit = ~|(diff & PART_MASK);
  assign hit_o    = partial_i ? part_hit : full_hit;

endmodule

// File: rtl/bus_strobe_ctl.sv
`timescale 1ns/1ps
module bus_strobe_ctl
  import bus_glue_pkg::*;
(
  input  logic psen_ni,
  input  logic rd_ni,
  input  logic wr_ni,
  output acc_t acc_o,
  output logic rom_oe_no,
  output logic ram_oe_no,
  output logic ram_we_no
);

  // fetch wins if the core ever drives both strobes
  always_comb begin
    acc_o.fetch   = ~psen_ni;
    acc_o.data_rd = psen_ni & ~rd_ni;
    acc_o.data_wr = psen_ni & ~wr_ni;
  end

  // active-low AND == active-high OR
  assign ram_oe_no = psen_ni & rd_ni;
  assign rom_oe_no = psen_ni;
  assign ram_we_no = wr_ni;

endmodule

// File: rtl/bus_chip_sel.sv
`timescale 1ns/1ps
module bus_chip_sel
  import bus_glue_pkg::*;
(
  input  win_hit_t hit_i,
  input  acc_t     acc_i,
  output logic     rom_ce_no,
  output logic     ram_ce_no,
  output logic     iox_ce_no,
  output logic     led_we_o
);

  logic data_acc;
  logic periph_data;

  always_comb begin
    data_acc    = acc_i.data_rd | acc_i.data_wr;
    periph_data = data_acc & (hit_i.led | hit_i.iox);
    rom_ce_no   = ~hit_i.rom;
    ram_ce_no   = ~(hit_i.ram & ~periph_data);
    iox_ce_no   = ~(hit_i.iox & data_acc);
    led_we_o    = hit_i.led & acc_i.data_wr;
  end

endmodule

// File: rtl/bus_led_reg.sv
`timescale 1ns/1ps
module bus_led_reg #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [DATA_W-1:0] d_i,
  output logic [DATA_W-1:0] q_o
);

  logic [DATA_W-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q <= '0;
    else if (we_i) q <= d_i;
  end

  assign q_o = q;

endmodule

// File: rtl/bus_glue.sv
`timescale 1ns/1ps
module bus_glue
  import bus_glue_pkg::*;
#(
  parameter int unsigned ADDR_W   = 16,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned PART_LSB = 12,
  parameter logic [ADDR_W-1:0] ROM_BASE = 16'h0000,
  parameter logic [ADDR_W-1:0] RAM_BASE = 16'h8000,
  parameter logic [ADDR_W-1:0] LED_BASE = 16'hF000,
  parameter logic [ADDR_W-1:0] IOX_BASE = 16'hD000,
  parameter int unsigned ROM_LSB  = 15,
  parameter int unsigned RAM_LSB  = 15,
  parameter int unsigned LED_LSB  = 0,
  parameter int unsigned IOX_SEL_W = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 partial_i,
  input  logic                 ale_i,
  input  logic [DATA_W-1:0]    ad_i,
  input  logic [ADDR_W-DATA_W-1:0] addr_hi_i,
  input  logic                 psen_ni,
  input  logic                 rd_ni,
  input  logic                 wr_ni,
  output logic [ADDR_W-1:0]    mem_addr_o,
  output logic                 eeprom_ce_no,
  output logic                 eeprom_oe_no,
  output logic                 sram_ce_no,
  output logic                 sram_oe_no,
  output logic                 sram_we_no,
  output logic                 iox_ce_no,
  output logic [IOX_SEL_W-1:0] iox_sel_o,
  output logic [DATA_W-1:0]    led_o
);

  localparam int unsigned LSB_W = 8;
  localparam logic [NUM_WIN*ADDR_W-1:0] WIN_BASE = {IOX_BASE, LED_BASE, RAM_BASE, ROM_BASE};
  localparam logic [NUM_WIN*LSB_W-1:0]  WIN_LSB  = {
    LSB_W'(IOX_SEL_W), LSB_W'(LED_LSB), LSB_W'(RAM_LSB), LSB_W'(ROM_LSB)};

  logic [DATA_W-1:0]  addr_lo;
  logic [ADDR_W-1:0]  addr;
  logic [NUM_WIN-1:0] hit_vec;
  win_hit_t           hit;
  acc_t               acc;
  logic               led_we;

  bus_addr_latch #(.LO_W(DATA_W)) u_latch (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ale_i  (ale_i),
    .ad_i   (ad_i),
    .lo_o   (addr_lo)
  );

  assign addr = {addr_hi_i, addr_lo};

  // code memories are split on the top bit only; mode affects peripherals
  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    bus_win_decode #(
      .ADDR_W   (ADDR_W),
      .BASE     (WIN_BASE[w*ADDR_W +: ADDR_W]),
      .FULL_LSB (int'(WIN_LSB[w*LSB_W +: LSB_W])),
      .PART_LSB (PART_LSB)
    ) u_dec (
      .addr_i    (addr),
      .partial_i (partial_i),
      .hit_o     (hit_vec[w])
    );
  end

  assign hit = win_hit_t'(hit_vec);

  bus_strobe_ctl u_strobe (
    .psen_ni   (psen_ni),
    .rd_ni     (rd_ni),
    .wr_ni     (wr_ni),
    .acc_o     (acc),
    .rom_oe_no (eeprom_oe_no),
    .ram_oe_no (sram_oe_no),
    .ram_we_no (sram_we_no)
  );

  bus_chip_sel u_sel (
    .hit_i     (hit),
    .acc_i     (acc),
    .rom_ce_no (eeprom_ce_no),
    .ram_ce_no (sram_ce_no),
    .iox_ce_no (iox_ce_no),
    .led_we_o  (led_we)
  );

  bus_led_reg #(.DATA_W(DATA_W)) u_led (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (led_we),
    .d_i    (ad_i),
    .q_o    (led_o)
  );

  assign mem_addr_o = addr;
  assign iox_sel_o  = addr[IOX_SEL_W-1:0];

endmodule

// File: rtl/bus_glue_chk.sv
`timescale 1ns/1ps
module bus_glue_chk #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ale_i,
  input logic [DATA_W-1:0] ad_i,
  input logic              psen_ni,
  input logic              rd_ni,
  input logic              wr_ni,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              eeprom_ce_no,
  input logic              sram_ce_no,
  input logic              sram_oe_no,
  input logic              iox_ce_no,
  input logic [DATA_W-1:0] led_o
);

  a_r1_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ale_i |=> mem_addr_o[DATA_W-1:0] == $past(ad_i));

  a_r1_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ale_i |=> $stable(mem_addr_o[DATA_W-1:0]));

  a_r2_low_half_rom: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_addr_o[ADDR_W-1] |-> (!eeprom_ce_no && sram_ce_no));

  a_r4_ram_oe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!psen_ni || !rd_ni) |-> !sram_oe_no);

  a_r6_iox_data_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !iox_ce_no |-> (psen_ni && (!rd_ni || !wr_ni)));

  a_r8_led_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ni |=> $stable(led_o));

  a_r10_one_ce: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({~eeprom_ce_no, ~sram_ce_no, ~iox_ce_no}) <= 1);

  a_r11_fetch_ram: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!psen_ni && mem_addr_o[ADDR_W-1]) |-> !sram_ce_no);

endmodule

bind bus_glue bus_glue_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bus_glue_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .ale_i        (ale_i),
  .ad_i         (ad_i),
  .psen_ni      (psen_ni),
  .rd_ni        (rd_ni),
  .wr_ni        (wr_ni),
  .mem_addr_o   (mem_addr_o),
  .eeprom_ce_no (eeprom_ce_no),
  .sram_ce_no   (sram_ce_no),
  .sram_oe_no   (sram_oe_no),
  .iox_ce_no    (iox_ce_no),
  .led_o        (led_o)
);

// File: tb/bus_glue_bench.sv
`timescale 1ns/1ps
module bus_glue_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       partial = 1'b0;
  logic       ale = 1'b0;
  logic [7:0] ad = '0;
  logic [7:0] addr_hi = '0;
  logic       psen_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [15:0] mem_addr;
  logic       rom_ce_n, rom_oe_n, ram_ce_n, ram_oe_n, ram_we_n, iox_ce_n;
  logic [1:0] iox_sel;
  logic [7:0] led;

  int total = 0;
  int bad   = 0;

  always #4 clk = ~clk;

  bus_glue u_bus_glue (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .partial_i    (partial),
    .ale_i        (ale),
    .ad_i         (ad),
    .addr_hi_i    (addr_hi),
    .psen_ni      (psen_n),
    .rd_ni        (rd_n),
    .wr_ni        (wr_n),
    .mem_addr_o   (mem_addr),
    .eeprom_ce_no (rom_ce_n),
    .eeprom_oe_no (rom_oe_n),
    .sram_ce_no   (ram_ce_n),
    .sram_oe_no   (ram_oe_n),
    .sram_we_no   (ram_we_n),
    .iox_ce_no    (iox_ce_n),
    .iox_sel_o    (iox_sel),
    .led_o        (led)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  // expected {rom_ce_n, ram_ce_n, iox_ce_n, iox_sel} from the requirements
  function automatic logic [4:0] exp_dec(input logic [15:0] a, input bit part,
                                         input bit ps_n, input bit r_n, input bit w_n);
    bit led_hit, iox_hit, data, periph;
    led_hit = part ? (a[15:12] == 4'hF) : (a == 16'hF000);
    iox_hit = part ? (a[15:12] == 4'hD) : (a[15:2] == 14'h3400);
    data    = ps_n && (!r_n || !w_n);
    periph  = data && (led_hit || iox_hit);
    return {a[15], !(a[15] && !periph), !(iox_hit && data), a[1:0]};
  endfunction

  task automatic sweep(input bit part, input int step);
    partial = part;
    ale = 1'b1;
    for (int a = 0; a < 65536; a += step) begin
      @(negedge clk);
      addr_hi = a[15:8];
      ad      = a[7:0];
      @(posedge clk);
      #0.5;
      chk(mem_addr == a[15:0], "R1 capture", {16'h0, mem_addr}, a);
      for (int p = 0; p < 4; p++) begin
        psen_n = (p != 1);
        rd_n   = (p != 2);
        wr_n   = (p != 3);
        #0.6;
        chk({rom_ce_n, ram_ce_n, iox_ce_n, iox_sel} ==
              exp_dec(a[15:0], part, psen_n, rd_n, wr_n),
            part ? "R2/R3/R7/R11 decode partial" : "R2/R3/R6/R11 decode complete",
            {27'h0, rom_ce_n, ram_ce_n, iox_ce_n, iox_sel},
            {27'h0, exp_dec(a[15:0], part, psen_n, rd_n, wr_n)});
        chk((int'(!rom_ce_n) + int'(!ram_ce_n) + int'(!iox_ce_n)) <= 1, "R10 one enable",
            {29'h0, rom_ce_n, ram_ce_n, iox_ce_n}, 32'h0);
        chk({ram_oe_n, ram_we_n, rom_oe_n} == {psen_n & rd_n, wr_n, psen_n}, "R4/R5 strobes",
            {29'h0, ram_oe_n, ram_we_n, rom_oe_n}, {29'h0, psen_n & rd_n, wr_n, psen_n});
      end
      psen_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
    end
    ale = 1'b0;
  endtask

  // one bus cycle: address phase then strobe across a rising edge
  task automatic bus_cyc(input logic [15:0] a, input logic [7:0] d, input bit is_wr);
    @(negedge clk);
    ale = 1'b1; addr_hi = a[15:8]; ad = a[7:0];
    @(negedge clk);
    ale = 1'b0; ad = d;
    if (is_wr) wr_n = 1'b0; else rd_n = 1'b0;
    #1;
    if (!is_wr && a == 16'hF000 && !partial)
      chk({rom_ce_n, ram_ce_n, iox_ce_n} == 3'b111, "R8 led read no enable",
          {29'h0, rom_ce_n, ram_ce_n, iox_ce_n}, 32'h7);
    @(negedge clk);
    wr_n = 1'b1; rd_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(led == 8'h00, "R9 led in reset", {24'h0, led}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(led == 8'h00, "R9 led after reset", {24'h0, led}, 32'h0);
    chk(mem_addr[7:0] == 8'h00, "R1 latch reset", {24'h0, mem_addr[7:0]}, 32'h0);

    // R1 hold after strobe falls
    ale = 1'b1; ad = 8'h34; addr_hi = 8'h12;
    @(negedge clk);
    ale = 1'b0; ad = 8'h99;
    @(negedge clk);
    @(negedge clk);
    chk(mem_addr == 16'h1234, "R1 hold", {16'h0, mem_addr}, 32'h1234);

    // R8 LED loading, complete mode
    partial = 1'b0;
    bus_cyc(16'hF000, 8'hA5, 1'b1);
    chk(led == 8'hA5, "R8 led write", {24'h0, led}, 32'hA5);
    bus_cyc(16'hF000, 8'h3C, 1'b0);
    chk(led == 8'hA5, "R8 led read no change", {24'h0, led}, 32'hA5);
    bus_cyc(16'hF001, 8'h11, 1'b1);
    chk(led == 8'hA5, "R6 led single byte", {24'h0, led}, 32'hA5);
    bus_cyc(16'hE000, 8'h22, 1'b1);
    chk(led == 8'hA5, "R8 sram write leaves led", {24'h0, led}, 32'hA5);
    // R7 alias write
    partial = 1'b1;
    bus_cyc(16'hF7FF, 8'h5A, 1'b1);
    chk(led == 8'h5A, "R7 led alias write", {24'h0, led}, 32'h5A);
    partial = 1'b0;

    sweep(1'b0, 1);
    sweep(1'b1, 4);

    chk(led == 8'h5A, "R8 sweep leaves led", {24'h0, led}, 32'h5A);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule